// File: doc/BRIEF.md
# Real-Time Clock Alarm Matcher with Per-Field Wildcards

This block decides, at every seconds update of a real-time clock, whether the alarm time has been reached. The clock's counting logic supplies the freshly updated seconds, minutes and hours bytes together with an update strobe. The alarm registers supply three alarm bytes. When every alarm byte agrees with its time byte, the block emits a single-cycle match pulse. The surrounding flag register turns that pulse into a latched alarm flag.

An alarm byte whose two top bits are both ones is a wildcard. A wildcard agrees with any value of its field. This lets software program an alarm that fires every second, once per minute, or once per hour. Both kinds of byte go through the same decoding before they are compared. That decoding honours the clock's data mode (BCD or plain binary) and its hour mode (12-hour with a PM flag in bit 7, or 24-hour). Encodings that look different but stand for the same time therefore still match.

The strobe is ignored while the clock is frozen for setting or while its divider is held in reset. The alarm bytes are only sampled on an update, so rewriting them never produces a pulse on its own.

Top module: `rtc_alarm_match`

## Requirements
- R1: When an update is accepted and each alarm byte decodes to the same value as its time byte, `alarm_pulse` is 1 in the clock cycle after `upd_stb`. When any non-wildcard field differs, `alarm_pulse` stays 0.
- R2: An alarm byte with bits 7 and 6 both set (value 0xC0 or above) is a wildcard and matches any value of its field. The remaining fields are still compared.
- R3: With all three alarm bytes as wildcards, every accepted update produces a pulse.
- R4: With the hours and minutes alarm bytes as wildcards and a fixed seconds byte, the pulse occurs exactly once per minute of stepped time, on the update whose seconds value equals the alarm seconds.
- R5: With `bin_mode`=0 every byte is read as BCD, with value = 10 x bits[7:4] + bits[3:0]. With `bin_mode`=1 the byte is used as a plain binary number. Alarm and time bytes are both decoded this way before comparison.
- R6: With `h24_mode`=0, an hours byte is normalised before comparison to (decode(bits[6:0]) mod 12) + 12 when bit 7 is set. With `h24_mode`=1 the whole hours byte is decoded as-is.
- R7: No pulse is produced for a strobe that arrives while `set_hold` or `div_rst` is 1.
- R8: `alarm_pulse` lasts exactly one cycle per accepted update. Changing alarm or time bytes without a strobe never produces a pulse.
- R9: While `rst_n` is 0, and in the first cycle after it, `alarm_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_stb | input | 1 | One-cycle strobe: time bytes hold the newly updated time |
| set_hold | input | 1 | Clock frozen for setting; updates are ignored |
| div_rst | input | 1 | Divider held in reset; updates are ignored |
| bin_mode | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| h24_mode | input | 1 | 1 = 24-hour hours byte, 0 = 12-hour with PM in bit 7 |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hour | input | 8 | Current hours byte |
| alm_sec | input | 8 | Alarm seconds byte |
| alm_min | input | 8 | Alarm minutes byte |
| alm_hour | input | 8 | Alarm hours byte |
| alarm_pulse | output | 1 | One-cycle match pulse, one cycle after the accepted strobe |

## Verification
Several corner cases are targeted directly:

- **Invalid BCD digits.** An alarm byte such as 0x1A is compared against 0x20 in both data modes. A matcher that compared raw bytes would miss the BCD match, and one that always decoded BCD would report a false match in binary mode.
- **12-hour midnight and noon.** Encodings such as 0x12 against 0x00 and 0x92 against 0x80 are tried in both hour modes. A missing modulo or a mishandled PM bit shows up as a wrong pulse.
- **Gating.** Strobes are issued under set-hold and divider reset, and alarm bytes are rewritten with no strobe. A design that leaked either would pulse when it should not.
- **Wildcard patterns.** A minute-wide stepped sequence is run with wildcard hours and minutes. Random mixes of modes and wildcards then cover the remaining combinations.

// File: rtl/rtcam_pkg.sv
package rtcam_pkg;
   localparam int unsigned FIELD_CNT = 3;
   localparam int unsigned HOURS_PER_HALF = 12;

   typedef enum logic [1:0] {
      FLD_SEC  = 2'd0,
      FLD_MIN  = 2'd1,
      FLD_HOUR = 2'd2
   } rtcam_field_e;
endpackage

// File: rtl/rtcam_bcd_decode.sv
module rtcam_bcd_decode #(
   parameter int unsigned RAW_W = 8,
   parameter int unsigned VAL_W = 8
) (
   input  logic [RAW_W-1:0] raw,
   input  logic             bin_mode,
   output logic [VAL_W-1:0] val
);
   localparam int unsigned NIB_W = RAW_W / 2;

   logic [VAL_W-1:0] tens_v;
   logic [VAL_W-1:0] ones_v;
   logic [VAL_W-1:0] bcd_v;

   generate
      if (RAW_W % 2 != 0) begin : g_bad_raw
         $error("rtcam_bcd_decode: RAW_W must be even");
      end
      if (VAL_W < RAW_W) begin : g_bad_val
         $error("rtcam_bcd_decode: VAL_W must be at least RAW_W");
      end
   endgenerate

   always_comb begin
      tens_v = VAL_W'(raw[RAW_W-1 -: NIB_W]);
      ones_v = VAL_W'(raw[NIB_W-1:0]);
      bcd_v  = VAL_W'(tens_v * VAL_W'(10)) + ones_v;
      val    = bin_mode ? VAL_W'(raw) : bcd_v;
   end
endmodule

// File: rtl/rtcam_hour_norm.sv
module rtcam_hour_norm
   import rtcam_pkg::*;
#(
   parameter int unsigned RAW_W = 8,
   parameter int unsigned VAL_W = 8
) (
   input  logic [RAW_W-1:0] raw,
   input  logic             bin_mode,
   input  logic             h24_mode,
   output logic [VAL_W-1:0] val
);
   logic [RAW_W-1:0] body;
   logic [VAL_W-1:0] lin;
   logic [VAL_W-1:0] half_v;

   // In 12-hour mode the PM flag sits in the top bit and is stripped before decode
   assign body = h24_mode ? raw : {1'b0, raw[RAW_W-2:0]};

   rtcam_bcd_decode #(.RAW_W(RAW_W), .VAL_W(VAL_W)) u_dec (
      .raw      (body),
      .bin_mode (bin_mode),
      .val      (lin)
   );

   always_comb begin
      half_v = lin % VAL_W'(HOURS_PER_HALF);
      if (h24_mode)
         val = lin;
      else if (raw[RAW_W-1])
         val = half_v + VAL_W'(HOURS_PER_HALF);
      else
         val = half_v;
   end
endmodule

// File: rtl/rtcam_match.sv
module rtcam_match #(
   parameter int unsigned N     = 3,
   parameter int unsigned VAL_W = 8
) (
   input  logic [N-1:0][VAL_W-1:0] alm_val,
   input  logic [N-1:0][VAL_W-1:0] cur_val,
   input  logic [N-1:0]            wild,
   output logic                    hit
);
   logic [N-1:0] field_ok;

   generate
      for (genvar i = 0; i < N; i++) begin : g_field
         assign field_ok[i] = wild[i] | (alm_val[i] == cur_val[i]);
      end
   endgenerate

   assign hit = &field_ok;
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
   import rtcam_pkg::*;
#(
   parameter int unsigned RAW_W     = 8,
   parameter int unsigned VAL_W     = 8,
   parameter int unsigned WILD_BITS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd_stb,
   input  logic             set_hold,
   input  logic             div_rst,
   input  logic             bin_mode,
   input  logic             h24_mode,
   input  logic [RAW_W-1:0] cur_sec,
   input  logic [RAW_W-1:0] cur_min,
   input  logic [RAW_W-1:0] cur_hour,
   input  logic [RAW_W-1:0] alm_sec,
   input  logic [RAW_W-1:0] alm_min,
   input  logic [RAW_W-1:0] alm_hour,
   output logic             alarm_pulse
);
   localparam int unsigned N = FIELD_CNT;

   generate
      if (RAW_W != 8) begin : g_bad_raw
         $error("rtc_alarm_match: time bytes are 8 bits wide");
      end
      if (WILD_BITS == 0 || WILD_BITS >= RAW_W) begin : g_bad_wild
         $error("rtc_alarm_match: WILD_BITS out of range");
      end
   endgenerate

   logic [N-1:0][RAW_W-1:0] alm_raw;
   logic [N-1:0][RAW_W-1:0] cur_raw;
   logic [N-1:0][VAL_W-1:0] alm_val;
   logic [N-1:0][VAL_W-1:0] cur_val;
   logic [N-1:0]            wild;
   logic                    hit;
   logic                    accept;
   logic                    pulse_q;

   assign alm_raw[FLD_SEC]  = alm_sec;
   assign alm_raw[FLD_MIN]  = alm_min;
   assign alm_raw[FLD_HOUR] = alm_hour;
   assign cur_raw[FLD_SEC]  = cur_sec;
   assign cur_raw[FLD_MIN]  = cur_min;
   assign cur_raw[FLD_HOUR] = cur_hour;

   generate
      for (genvar i = 0; i < N; i++) begin : g_dec
         assign wild[i] = &alm_raw[i][RAW_W-1 -: WILD_BITS];
         if (i == int'(FLD_HOUR)) begin : g_hour
            rtcam_hour_norm #(.RAW_W(RAW_W), .VAL_W(VAL_W)) u_alm (
               .raw(alm_raw[i]), .bin_mode(bin_mode), .h24_mode(h24_mode), .val(alm_val[i]));
            rtcam_hour_norm #(.RAW_W(RAW_W), .VAL_W(VAL_W)) u_cur (
               .raw(cur_raw[i]), .bin_mode(bin_mode), .h24_mode(h24_mode), .val(cur_val[i]));
         end else begin : g_plain
            rtcam_bcd_decode #(.RAW_W(RAW_W), .VAL_W(VAL_W)) u_alm (
               .raw(alm_raw[i]), .bin_mode(bin_mode), .val(alm_val[i]));
            rtcam_bcd_decode #(.RAW_W(RAW_W), .VAL_W(VAL_W)) u_cur (
               .raw(cur_raw[i]), .bin_mode(bin_mode), .val(cur_val[i]));
         end
      end
   endgenerate

   rtcam_match #(.N(N), .VAL_W(VAL_W)) u_match (
      .alm_val (alm_val),
      .cur_val (cur_val),
      .wild    (wild),
      .hit     (hit)
   );

   // A strobe counts only when the clock is actually running
   assign accept = upd_stb & ~set_hold & ~div_rst;

   always_ff @(posedge clk) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= accept & hit;
   end

   assign alarm_pulse = pulse_q;
endmodule

// File: rtl/rtc_alarm_match_chk.sv
module rtc_alarm_match_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       upd_stb,
   input logic       set_hold,
   input logic       div_rst,
   input logic [7:0] cur_sec,
   input logic [7:0] cur_min,
   input logic [7:0] cur_hour,
   input logic [7:0] alm_sec,
   input logic [7:0] alm_min,
   input logic [7:0] alm_hour,
   input logic       alarm_pulse
);
   logic run_ok;
   logic all_wild;
   logic same_bytes;

   assign run_ok     = upd_stb && !set_hold && !div_rst;
   assign all_wild   = (&alm_sec[7:6]) && (&alm_min[7:6]) && (&alm_hour[7:6]);
   assign same_bytes = (alm_sec == cur_sec) && (alm_min == cur_min) && (alm_hour == cur_hour);

   // R8: every pulse is caused by a strobe in the previous cycle
   a_r8_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_pulse |-> $past(upd_stb));

   // R8: without a fresh strobe the pulse does not stretch
   a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_pulse && !upd_stb) |=> !alarm_pulse);

   // R7: hold conditions block the pulse
   a_r7_not_held: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_pulse |-> (!$past(set_hold) && !$past(div_rst)));

   // R3: all-wildcard alarm fires on every accepted update
   a_r3_all_wild: assert property (@(posedge clk) disable iff (!rst_n)
      (run_ok && all_wild) |=> alarm_pulse);

   // R1: identical alarm and time bytes always match
   a_r1_identical: assert property (@(posedge clk) disable iff (!rst_n)
      (run_ok && same_bytes) |=> alarm_pulse);
endmodule

bind rtc_alarm_match rtc_alarm_match_chk u_chk (
   .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .set_hold(set_hold), .div_rst(div_rst),
   .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
   .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
   .alarm_pulse(alarm_pulse));

// File: tb/sim_rtc_alarm_match.sv
module sim_rtc_alarm_match;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic upd_stb = 1'b0, set_hold = 1'b0, div_rst = 1'b0;
   logic bin_mode = 1'b0, h24_mode = 1'b1;
   logic [7:0] cur_sec = 8'h00, cur_min = 8'h00, cur_hour = 8'h00;
   logic [7:0] alm_sec = 8'h00, alm_min = 8'h00, alm_hour = 8'h00;
   logic alarm_pulse;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   rtc_alarm_match u0 (
      .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .set_hold(set_hold), .div_rst(div_rst),
      .bin_mode(bin_mode), .h24_mode(h24_mode),
      .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
      .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
      .alarm_pulse(alarm_pulse));

   function automatic int dec(input logic [7:0] b, input logic bin);
      return bin ? int'(b) : int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction

   function automatic int hour_of(input logic [7:0] b, input logic bin, input logic h24);
      if (h24) return dec(b, bin);
      return (dec({1'b0, b[6:0]}, bin) % 12) + (b[7] ? 12 : 0);
   endfunction

   function automatic logic [7:0] enc(input int v, input logic bin);
      logic [3:0] hi, lo;
      hi = 4'(v / 10);
      lo = 4'(v % 10);
      return bin ? 8'(v) : {hi, lo};
   endfunction

   function automatic logic [7:0] enc_hour(input int h, input logic bin, input logic h24);
      int h12;
      if (h24) return enc(h, bin);
      h12 = (h % 12 == 0) ? 12 : h % 12;
      return enc(h12, bin) | ((h >= 12) ? 8'h80 : 8'h00);
   endfunction

   function automatic logic expect_hit();
      logic ok;
      ok = 1'b1;
      if (!(alm_sec[7] && alm_sec[6]) && dec(alm_sec, bin_mode) != dec(cur_sec, bin_mode)) ok = 1'b0;
      if (!(alm_min[7] && alm_min[6]) && dec(alm_min, bin_mode) != dec(cur_min, bin_mode)) ok = 1'b0;
      if (!(alm_hour[7] && alm_hour[6]) &&
          hour_of(alm_hour, bin_mode, h24_mode) != hour_of(cur_hour, bin_mode, h24_mode)) ok = 1'b0;
      return ok && !set_hold && !div_rst;
   endfunction

   task automatic check(input logic act, input logic exp, input string req);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: alarm_pulse=%0b expected=%0b", req, act, exp);
      end
   endtask

   // Strobe for one cycle, sample the registered pulse, then confirm it dropped
   task automatic update_and_check(input string req);
      logic exp;
      exp = expect_hit();
      @(negedge clk) upd_stb = 1'b1;
      @(negedge clk) upd_stb = 1'b0;
      check(alarm_pulse, exp, req);
      @(negedge clk);
      check(alarm_pulse, 1'b0, "R8");
   endtask

   task automatic set_all(input logic [7:0] cs, cm, ch, as, am, ah);
      cur_sec = cs; cur_min = cm; cur_hour = ch;
      alm_sec = as; alm_min = am; alm_hour = ah;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int pulses;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check(alarm_pulse, 1'b0, "R9");
      upd_stb = 1'b1;
      set_all(8'h00, 8'h00, 8'h00, 8'hC0, 8'hC0, 8'hC0);
      @(negedge clk);
      check(alarm_pulse, 1'b0, "R9");
      upd_stb = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check(alarm_pulse, 1'b0, "R9");

      // R1 exact match, then a one-field mismatch
      bin_mode = 1'b0; h24_mode = 1'b1;
      set_all(8'h56, 8'h34, 8'h12, 8'h56, 8'h34, 8'h12);
      update_and_check("R1");
      alm_sec = 8'h57;
      update_and_check("R1");
      // R2 seconds wildcard, minutes still compared
      alm_sec = 8'hC5;
      update_and_check("R2");
      alm_min = 8'h35;
      update_and_check("R2");
      // R3 all wildcards on several times
      set_all(8'h00, 8'h00, 8'h00, 8'hFF, 8'hC0, 8'hD3);
      for (int k = 0; k < 4; k++) begin
         cur_sec = enc(k * 13, 1'b0);
         update_and_check("R3");
      end
      // R5 invalid BCD digit: 0x1A decodes to 20 in BCD only
      set_all(8'h20, 8'h00, 8'h00, 8'h1A, 8'h00, 8'h00);
      bin_mode = 1'b0;
      update_and_check("R5");
      bin_mode = 1'b1;
      update_and_check("R5");
      set_all(8'd59, 8'd7, 8'd23, 8'd59, 8'd7, 8'd23);
      update_and_check("R5");
      // R6 12-hour normalisation
      bin_mode = 1'b0;
      set_all(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h12);
      h24_mode = 1'b0;
      update_and_check("R6");
      h24_mode = 1'b1;
      update_and_check("R6");
      h24_mode = 1'b0;
      cur_hour = 8'h80; alm_hour = 8'h92;
      update_and_check("R6");
      alm_hour = 8'h12;
      update_and_check("R6");
      // R7 hold conditions
      set_all(8'h10, 8'h10, 8'h10, 8'hC0, 8'hC0, 8'hC0);
      h24_mode = 1'b1;
      set_hold = 1'b1;
      update_and_check("R7");
      set_hold = 1'b0; div_rst = 1'b1;
      update_and_check("R7");
      div_rst = 1'b0;
      update_and_check("R7");
      // R8 alarm rewrites without strobe never pulse
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         alm_sec = 8'(k * 7); cur_sec = 8'(k * 7);
         @(negedge clk);
         check(alarm_pulse, 1'b0, "R8");
      end
      // R4 once-a-minute alarm across two minutes
      bin_mode = 1'b1; h24_mode = 1'b1;
      set_all(8'd0, 8'd0, 8'd5, 8'd30, 8'hC0, 8'hC0);
      pulses = 0;
      for (int s = 0; s < 120; s++) begin
         cur_sec = 8'(s % 60); cur_min = 8'(s / 60);
         @(negedge clk) upd_stb = 1'b1;
         @(negedge clk) upd_stb = 1'b0;
         if (alarm_pulse === 1'b1) pulses++;
      end
      checks++;
      if (pulses != 2) begin
         fails++;
         $display("FAIL R4: pulses=%0d expected=2", pulses);
      end
      // Random mix
      for (int it = 0; it < 400; it++) begin
         int hs, ms, ss;
         bin_mode = 1'($urandom % 2);
         h24_mode = 1'($urandom % 2);
         set_hold = (($urandom % 10) == 0);
         div_rst  = (($urandom % 12) == 0);
         ss = $urandom % 60; ms = $urandom % 60; hs = $urandom % 24;
         cur_sec = enc(ss, bin_mode);
         cur_min = enc(ms, bin_mode);
         cur_hour = enc_hour(hs, bin_mode, h24_mode);
         case ($urandom % 4)
            0: alm_sec = 8'hC0 | 8'($urandom % 64);
            1: alm_sec = cur_sec;
            2: alm_sec = enc($urandom % 60, bin_mode);
            default: alm_sec = 8'($urandom);
         endcase
         case ($urandom % 4)
            0: alm_min = 8'hC0 | 8'($urandom % 64);
            1: alm_min = cur_min;
            2: alm_min = enc($urandom % 60, bin_mode);
            default: alm_min = 8'($urandom);
         endcase
         case ($urandom % 4)
            0: alm_hour = 8'hC0 | 8'($urandom % 64);
            1: alm_hour = enc_hour(hs, bin_mode, h24_mode);
            2: alm_hour = enc_hour($urandom % 24, bin_mode, h24_mode);
            default: alm_hour = 8'($urandom);
         endcase
         update_and_check("R1 R2 R5 R6 R7 random");
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule